// File: doc/BRIEF.md
# CPU Hot-Plug Presence Map and Interrupt Source

This block keeps a record of which processors are installed and raises a level interrupt toward the guest whenever that record changes. Each processor is tracked by one bit in a 256-bit map. Software reads the map one byte at a time over a byte-wide I/O bus. The map is loaded from a start-up population vector while reset is held. After that, plug and unplug requests, each tagged with a processor number, edit it.

Every accepted processor event also latches a shared event status flag. A second hot-plug source, for expansion slots, latches a neighbouring flag. Software clears either flag by writing a one to it, and masks each one through an enable register. The interrupt line is registered. It is high when an enabled hot-plug flag is pending or when the surrounding power-management logic reports an enabled fixed event.

Top module: `cpu_hotplug_sci`

## Requirements
- R1: While `rst` is high, the map takes the value of `presenceInit`, with processor n in bit n. The event status register, the enable register, `ioRdata`, `sciOut` and `idErr` all clear to zero.
- R2: A read strobe on address 0xAF00+k, for k = 0..31, returns map byte k on `ioRdata` on the following cycle. Bit j of that byte is processor 8k+j, and bit 0 is the least significant bit. A read of any address that is not mapped returns 0x00.
- R3: A plug request sets the bit of processor `reqId`, and an unplug request clears it. When plug and unplug requests arrive in the same cycle, the plug request wins.
- R4: Every accepted plug or unplug request sets event status bit 2 (value 0x04). A pulse on `pciHpReq` sets event status bit 1 (value 0x02).
- R5: The event status register is at 0xAF20 and is cleared by writing ones to it. Bits written as zero keep their value. The enable register is at 0xAF21 and can be both read and written.
- R6: If an event sets a status bit in the same cycle that a write of one clears that bit, the bit stays set.
- R7: Writes to the map window 0xAF00..0xAF1F leave the map unchanged.
- R8: A request whose `reqId` is 256 or above changes neither the map nor the status register. It sets `idErr`, which stays high until reset.
- R9: `sciOut` is a register. After each clock edge it holds ((status AND enable AND 0x06) != 0) OR `fixedEvtPending`, taken from the values present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioAddr | input | 16 | I/O byte address |
| ioRd | input | 1 | Read strobe, one cycle |
| ioWr | input | 1 | Write strobe, one cycle |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, registered |
| plugReq | input | 1 | Processor added |
| unplugReq | input | 1 | Processor removed |
| reqId | input | 9 | Processor number of the request |
| pciHpReq | input | 1 | Slot hot-plug event |
| fixedEvtPending | input | 1 | Enabled fixed power-management event pending |
| presenceInit | input | 256 | Processors present at start-up |
| sciOut | output | 1 | System control interrupt level |
| idErr | output | 1 | Sticky flag for an out-of-range request |

## Verification
Two functions can act on the same status bit in one cycle: a hot-plug event sets it, and a software write of one clears it. The bench drives a plug request and a write of 0x04 to 0xAF20 on the same clock edge, then reads the status register back. The bit must still be set, and the interrupt must rise again. A behavioural model updates on every edge and is compared with the interrupt, the error flag and each read result, so the outcome of the collision also shows on the ports.

// File: rtl/cph_pkg.sv
`timescale 1ns/1ps
package cph_pkg;
  localparam int NUM_IDS = 256;
  localparam int MAP_BYTES = NUM_IDS / 8;
  localparam int BIT_W = $clog2(NUM_IDS);
  localparam int BYTE_W = $clog2(MAP_BYTES);
  localparam logic [7:0] HP_MASK = 8'h06;

  typedef enum logic [1:0] {RD_NONE, RD_MAP, RD_STS, RD_EN} rdSel_e;

  typedef struct packed {
    logic              bmSet;
    logic              bmClr;
    logic [BIT_W-1:0]  bitIdx;
    logic              stsSetCpu;
    logic              stsSetPci;
    logic [7:0]        stsClr;
    logic              enWr;
    logic [7:0]        wrData;
    logic              rdStb;
    rdSel_e            rdSel;
    logic [BYTE_W-1:0] rdByte;
  } ctlStrb_t;
endpackage

// File: rtl/cph_ctrl.sv
`timescale 1ns/1ps
module cph_ctrl
  import cph_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hAF00,
  parameter logic [ADDR_W-1:0] STS_ADDR = 16'hAF20,
  parameter logic [ADDR_W-1:0] EN_ADDR = 16'hAF21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWdata,
  input  logic              plugReq,
  input  logic              unplugReq,
  input  logic [ID_W-1:0]   reqId,
  input  logic              pciHpReq,
  output ctlStrb_t          strb,
  output logic              idErr
);
  localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + ADDR_W'(MAP_BYTES);

  logic inWin;
  logic idOk;
  logic reqAny;
  logic [ADDR_W-1:0] winOff;

  always_comb begin
    inWin  = (ioAddr >= WIN_BASE) && (ioAddr < WIN_END);
    winOff = ioAddr - WIN_BASE;
    idOk   = reqId < ID_W'(NUM_IDS);
    reqAny = plugReq || unplugReq;

    strb.bmSet     = plugReq && idOk;
    strb.bmClr     = unplugReq && !plugReq && idOk;
    strb.bitIdx    = BIT_W'(reqId);
    strb.stsSetCpu = reqAny && idOk;
    strb.stsSetPci = pciHpReq;
    strb.stsClr    = (ioWr && ioAddr == STS_ADDR) ? ioWdata : 8'h00;
    strb.enWr      = ioWr && (ioAddr == EN_ADDR);
    strb.wrData    = ioWdata;
    strb.rdStb     = ioRd;
    strb.rdByte    = BYTE_W'(winOff);
    if (inWin)                 strb.rdSel = RD_MAP;
    else if (ioAddr == STS_ADDR) strb.rdSel = RD_STS;
    else if (ioAddr == EN_ADDR)  strb.rdSel = RD_EN;
    else                       strb.rdSel = RD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                 idErr <= 1'b0;
    else if (reqAny && !idOk) idErr <= 1'b1;
  end

  AST_BAD_ID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (reqAny && reqId >= ID_W'(NUM_IDS)) |-> !(strb.bmSet || strb.bmClr || strb.stsSetCpu)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    idErr |=> idErr); // R8
  AST_BAD_ID_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (reqAny && reqId >= ID_W'(NUM_IDS)) |=> idErr); // R8
endmodule

// File: rtl/cph_dp.sv
`timescale 1ns/1ps
module cph_dp
  import cph_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctlStrb_t           strb,
  input  logic [NUM_IDS-1:0] presenceInit,
  input  logic               fixedEvtPending,
  output logic [7:0]         ioRdata,
  output logic               sciOut
);
  logic [NUM_IDS-1:0] bmFlat;
  logic [7:0] sts;
  logic [7:0] en;
  logic [7:0] stsSet;

  for (genvar b = 0; b < NUM_IDS; b++) begin : g_bit
    logic hit;
    assign hit = (strb.bitIdx == BIT_W'(b));
    always_ff @(posedge clk) begin
      if (rst)                     bmFlat[b] <= presenceInit[b];
      else if (strb.bmSet && hit) bmFlat[b] <= 1'b1;
      else if (strb.bmClr && hit) bmFlat[b] <= 1'b0;
    end
  end

  assign stsSet = {5'b0, strb.stsSetCpu, strb.stsSetPci, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= 8'h00;
      en  <= 8'h00;
    end else begin
      sts <= (sts & ~strb.stsClr) | stsSet;
      if (strb.enWr) en <= strb.wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ioRdata <= 8'h00;
    end else if (strb.rdStb) begin
      case (strb.rdSel)
        RD_MAP:  ioRdata <= bmFlat[strb.rdByte*8 +: 8];
        RD_STS:  ioRdata <= sts;
        RD_EN:   ioRdata <= en;
        default: ioRdata <= 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sciOut <= 1'b0;
    else     sciOut <= (|(sts & en & HP_MASK)) || fixedEvtPending;
  end

  AST_PLUG_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    strb.bmSet |=> bmFlat[$past(strb.bitIdx)]); // R3
  AST_UNPLUG_CLEARS_BIT: assert property (@(posedge clk) disable iff (rst)
    strb.bmClr |=> !bmFlat[$past(strb.bitIdx)]); // R3
  AST_CPU_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    strb.stsSetCpu |=> sts[2]); // R6
  AST_PCI_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    strb.stsSetPci |=> sts[1]); // R4
  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !(strb.bmSet || strb.bmClr) |=> $stable(bmFlat)); // R7
  AST_SCI_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(sts & en & HP_MASK)) |=> sciOut); // R9
  AST_SCI_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!(|(sts & en & HP_MASK)) && !fixedEvtPending) |=> !sciOut); // R9
endmodule

// File: rtl/cpu_hotplug_sci.sv
`timescale 1ns/1ps
module cpu_hotplug_sci
  import cph_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [15:0]  ioAddr,
  input  logic         ioRd,
  input  logic         ioWr,
  input  logic [7:0]   ioWdata,
  output logic [7:0]   ioRdata,
  input  logic         plugReq,
  input  logic         unplugReq,
  input  logic [8:0]   reqId,
  input  logic         pciHpReq,
  input  logic         fixedEvtPending,
  input  logic [255:0] presenceInit,
  output logic         sciOut,
  output logic         idErr
);
  ctlStrb_t strb;

  cph_ctrl #(.ADDR_W(16), .ID_W(9)) u_ctrl (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .plugReq(plugReq), .unplugReq(unplugReq),
    .reqId(reqId), .pciHpReq(pciHpReq), .strb(strb), .idErr(idErr)
  );

  cph_dp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .presenceInit(presenceInit),
    .fixedEvtPending(fixedEvtPending), .ioRdata(ioRdata), .sciOut(sciOut)
  );
endmodule

// File: tb/tb_cpu_hotplug_sci.sv
`timescale 1ns/1ps
module tb_cpu_hotplug_sci;
  logic clk = 0;
  logic rst = 1;
  logic [15:0] ioAddr = 0;
  logic ioRd = 0, ioWr = 0;
  logic [7:0] ioWdata = 0;
  logic [7:0] ioRdata;
  logic plugReq = 0, unplugReq = 0;
  logic [8:0] reqId = 0;
  logic pciHpReq = 0, fixedEvtPending = 0;
  logic [255:0] presenceInit = {192'h0, 64'h8000_0000_0000_0003};
  logic sciOut, idErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference model state
  bit [255:0] mBm;
  bit [7:0] mSts, mEn, mRd;
  bit mSci, mErr, mRdValid;

  always #10 clk = ~clk;

  cpu_hotplug_sci dut (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .plugReq(plugReq),
    .unplugReq(unplugReq), .reqId(reqId), .pciHpReq(pciHpReq),
    .fixedEvtPending(fixedEvtPending), .presenceInit(presenceInit),
    .sciOut(sciOut), .idErr(idErr)
  );

  always @(posedge clk) begin
    int id;
    bit [7:0] setBits, clrBits;
    if (rst) begin
      mBm = presenceInit; mSts = 0; mEn = 0; mRd = 0; mSci = 0; mErr = 0; mRdValid = 0;
    end else begin
      mRdValid = ioRd;
      if (ioRd) begin
        if (ioAddr >= 16'hAF00 && ioAddr <= 16'hAF1F) begin
          id = (ioAddr - 16'hAF00) * 8;
          for (int j = 0; j < 8; j++) mRd[j] = mBm[id + j];
        end else if (ioAddr == 16'hAF20) mRd = mSts;
        else if (ioAddr == 16'hAF21) mRd = mEn;
        else mRd = 0;
      end
      mSci = ((mSts & mEn & 8'h06) != 0) || fixedEvtPending;
      setBits = 0;
      if (plugReq || unplugReq) begin
        id = reqId;
        if (id >= 256) mErr = 1;
        else begin
          mBm[id] = plugReq ? 1'b1 : 1'b0;
          setBits[2] = 1;
        end
      end
      if (pciHpReq) setBits[1] = 1;
      clrBits = (ioWr && ioAddr == 16'hAF20) ? ioWdata : 8'h00;
      mSts = (mSts & ~clrBits) | setBits;
      if (ioWr && ioAddr == 16'hAF21) mEn = ioWdata;
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 sciOut vs model", sciOut, mSci);
      check("R8 idErr vs model", idErr, mErr);
      if (mRdValid) check("R2 ioRdata vs model", ioRdata, mRd);
    end
  end

  task automatic rdAt(input logic [15:0] a, output logic [7:0] v);
    ioAddr = a; ioRd = 1;
    @(negedge clk);
    ioRd = 0; v = ioRdata;
  endtask

  task automatic wrAt(input logic [15:0] a, input logic [7:0] d);
    ioAddr = a; ioWdata = d; ioWr = 1;
    @(negedge clk);
    ioWr = 0;
  endtask

  task automatic req(input bit p, input bit u, input int id);
    plugReq = p; unplugReq = u; reqId = 9'(id);
    @(negedge clk);
    plugReq = 0; unplugReq = 0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 sciOut after reset", sciOut, 0);
    check("R1 idErr after reset", idErr, 0);
    rdAt(16'hAF00, v); check("R1 map byte 0", v, 8'h03);
    rdAt(16'hAF07, v); check("R1 map byte 7", v, 8'h80);
    rdAt(16'hAF20, v); check("R1 status", v, 8'h00);
    rdAt(16'hAF21, v); check("R1 enable", v, 8'h00);

    req(1, 0, 10);
    rdAt(16'hAF01, v); check("R3 plug id 10", v, 8'h04);
    rdAt(16'hAF20, v); check("R4 cpu status bit", v, 8'h04);
    req(0, 1, 1);
    rdAt(16'hAF00, v); check("R3 unplug id 1", v, 8'h01);
    req(1, 1, 255);
    rdAt(16'hAF1F, v); check("R3 plug wins", v, 8'h80);
    pciHpReq = 1; @(negedge clk); pciHpReq = 0;
    rdAt(16'hAF20, v); check("R4 pci status bit", v, 8'h06);

    wrAt(16'hAF21, 8'h04);
    rdAt(16'hAF21, v); check("R5 enable readback", v, 8'h04);
    check("R9 sci raised", sciOut, 1);
    wrAt(16'hAF20, 8'h04);
    rdAt(16'hAF20, v); check("R5 w1c status", v, 8'h02);
    @(negedge clk);
    check("R9 sci dropped", sciOut, 0);

    ioAddr = 16'hAF20; ioWdata = 8'h04; ioWr = 1;
    plugReq = 1; reqId = 9'd20;
    @(negedge clk);
    ioWr = 0; plugReq = 0;
    rdAt(16'hAF20, v); check("R6 set beats clear", v, 8'h06);
    rdAt(16'hAF02, v); check("R3 plug id 20", v, 8'h10);
    check("R6 sci re-raised", sciOut, 1);
    wrAt(16'hAF20, 8'h06);
    rdAt(16'hAF20, v); check("R5 w1c both", v, 8'h00);

    wrAt(16'hAF00, 8'hFF);
    wrAt(16'hAF05, 8'h5A);
    rdAt(16'hAF00, v); check("R7 window write ignored", v, 8'h01);
    rdAt(16'hAF05, v); check("R7 window write ignored b5", v, 8'h00);

    req(1, 0, 300);
    check("R8 error raised", idErr, 1);
    rdAt(16'hAF20, v); check("R8 status untouched", v, 8'h00);
    rdAt(16'hAF05, v); check("R8 map untouched", v, 8'h00);
    req(0, 1, 511);
    rdAt(16'hAF1F, v); check("R8 map untouched top", v, 8'h80);
    check("R8 error sticky", idErr, 1);

    fixedEvtPending = 1; @(negedge clk); fixedEvtPending = 0;
    check("R9 fixed event", sciOut, 1);
    @(negedge clk);
    check("R9 fixed event gone", sciOut, 0);

    rdAt(16'h1234, v); check("R2 unmapped read", v, 8'h00);
    rdAt(16'hAF22, v); check("R2 past enable", v, 8'h00);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule